// File: doc/BRIEF.md
# Selectable-Length Serial Shift Port

This block is a clocked serial shifter that borrows four pins of a general-purpose port. When it is enabled, pin 0 carries serial input, pin 1 serial output, pin 2 the serial clock and pin 3 stays an ordinary port pin. When it is disabled, all four pins pass the port's own output and output-enable values, and pin 3 (active low) is the external interrupt source. Software picks, through a mode register, whether a transfer is 4 or 8 bits long. It also picks whether the block drives the serial clock from an internal divider (master) or follows a clock arriving on pin 2 (slave).

A transfer starts when the data register is written while the port is enabled and idle. Bits leave most significant first and change on the falling serial clock edge. Incoming bits are taken on the rising edge. In a 4-bit transfer only the lower nibble takes part. When the last bit has been taken, a completion flag is set. While the port is enabled this flag drives the shared interrupt request, and software can also read it. The external serial clock, the serial input and the interrupt pin each pass through a two-flop synchroniser. A slave clock period of 2.0 µs or more is therefore far slower than the block clock.

The controller is a four-state machine:
- ST_IDLE: idle, waiting for a start.
- ST_WAIT_FALL: waiting for a falling clock edge. On that edge the next output bit is presented.
- ST_WAIT_RISE: waiting for a rising clock edge. On that edge an input bit is shifted in.
- ST_FINISH: a single cycle that sets the flag.

Transitions:
- ST_IDLE to ST_WAIT_FALL on a data write while enabled.
- ST_WAIT_FALL to ST_WAIT_RISE on a falling edge.
- ST_WAIT_RISE to ST_WAIT_FALL on a rising edge that is not the last one.
- ST_WAIT_RISE to ST_FINISH on the last rising edge.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `sio_shift_port`

## Requirements
- R1: After reset the mode register reads 0 (disabled, slave, 4-bit) and the status register reads 0.
- R2: While disabled, pad_out and pad_oe equal gpio_out and gpio_oe, and irq_req is the inverse of pad_in[3] delayed by a two-flop synchroniser.
- R3: While enabled, pad_oe[0] is 0, pad_oe[1] is 1 with pad_out[1] carrying serial data, pad_oe[2] is 1 only in master mode, and pin 3 keeps gpio_out[3]/gpio_oe[3].
- R4: An 8-bit transfer presents data bits 7 down to 0 on pad_out[1], each stable at the rising clock edge. Afterwards the data register holds the eight input bits, the first one received in bit 7.
- R5: A 4-bit transfer presents bits 3 down to 0. It replaces only bits 3:0 with the four input bits and leaves bits 7:4 unchanged.
- R6: In master mode pad_out[2] idles high, and each of its low and high phases lasts HALF_DIV block clock cycles.
- R7: In slave mode the transfer follows the clock driven on pad_in[2], after synchronisation.
- R8: Completion sets the status flag (status bit 0) and, while enabled, irq_req. The flag holds until a status write with bit 0 set or the next start clears it.
- R9: A data write during a transfer leaves the data register unchanged and sets the sticky error bit (status bit 1). A status write with bit 1 set clears it.
- R10: The mode register reads back {len8 (bit 2), master (bit 1), enable (bit 0)}. A mode write during a transfer is ignored. Status bit 2 reads 1 while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 mode, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| gpio_out | input | 4 | Port output values from the general-purpose port |
| gpio_oe | input | 4 | Port output enables from the general-purpose port |
| pad_in | input | 4 | Pin input levels |
| pad_out | output | 4 | Pin output levels after the function mux |
| pad_oe | output | 4 | Pin output enables after the function mux |
| irq_req | output | 1 | Shared interrupt request |
| xfer_flag | output | 1 | Completion flag, for polling |

## Verification
If the bit counter or a state is wrong, the transfer ends early or late. The scoreboard then either runs out of expected serial bits or has some left over, and the data register read just after completion shows a shifted or partly updated value. A nibble-select fault shows up at once in the first 4-bit transfer as changed bits 7:4. A fault in the divider or synchroniser shows up within the first half-period as a wrong measured phase length, or as serial output that is not stable at the rising clock edge. Faults in the sticky flag or error bit show up on the status read that follows the triggering event.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_FALL = 2'd1,
        ST_WAIT_RISE = 2'd2,
        ST_FINISH    = 2'd3
    } sio_state_t;

    typedef struct packed {
        logic len8;
        logic master;
        logic en;
    } sio_mode_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/sio_master_clk.sv
module sio_master_clk #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic want_fall_i,
    output logic fall_o,
    output logic rise_o,
    output logic sck_o
);
    localparam int              CW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0]   TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          sck_q;
    logic          tick;

    assign tick   = run_i && (cnt_q == TOP);
    assign fall_o = tick && want_fall_i;
    assign rise_o = tick && !want_fall_i;
    assign sck_o  = sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (!run_i) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= !want_fall_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // half-phase must not shorten: sck only moves on a completed count
    AST_SCK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick) |=> (sck_q == $past(sck_q))); // R6
endmodule

// File: rtl/sio_shift_ctrl.sv
module sio_shift_ctrl
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    input  logic       fall_ev_i,
    input  logic       rise_ev_i,
    input  logic       si_i,
    output sio_mode_t  mode_o,
    output logic [7:0] data_o,
    output logic       so_o,
    output logic       flag_o,
    output logic       err_o,
    output logic       busy_o,
    output logic       shifting_o,
    output logic       want_fall_o
);
    sio_state_t state_q, state_d;
    sio_mode_t  mode_q;
    logic [7:0] shreg_q;
    logic [3:0] bit_cnt_q;
    logic       so_q, flag_q, err_q;
    logic       data_wr, mode_wr, stat_wr, start, last_bit;

    assign data_wr  = wr_i && (addr_i == ADDR_DATA);
    assign mode_wr  = wr_i && (addr_i == ADDR_MODE);
    assign stat_wr  = wr_i && (addr_i == ADDR_STAT);
    assign start    = data_wr && (state_q == ST_IDLE) && mode_q.en;
    assign last_bit = mode_q.len8 ? (bit_cnt_q == 4'd7) : (bit_cnt_q == 4'd3);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)     state_d = ST_WAIT_FALL;
            ST_WAIT_FALL: if (fall_ev_i) state_d = ST_WAIT_RISE;
            ST_WAIT_RISE: if (rise_ev_i) state_d = last_bit ? ST_FINISH : ST_WAIT_FALL;
            ST_FINISH:                   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            so_q      <= 1'b1;
            flag_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (mode_wr && state_q == ST_IDLE)
                mode_q <= '{len8: wdata_i[2], master: wdata_i[1], en: wdata_i[0]};

            if (data_wr && state_q == ST_IDLE)
                shreg_q <= wdata_i;
            else if (state_q == ST_WAIT_RISE && rise_ev_i) begin
                if (mode_q.len8) shreg_q      <= {shreg_q[6:0], si_i};
                else             shreg_q[3:0] <= {shreg_q[2:0], si_i};
            end

            if (start)
                bit_cnt_q <= '0;
            else if (state_q == ST_WAIT_RISE && rise_ev_i)
                bit_cnt_q <= bit_cnt_q + 1'b1;

            if (state_q == ST_WAIT_FALL && fall_ev_i)
                so_q <= mode_q.len8 ? shreg_q[7] : shreg_q[3];

            if (state_q == ST_FINISH)
                flag_q <= 1'b1;
            else if (start || (stat_wr && wdata_i[0]))
                flag_q <= 1'b0;

            if (data_wr && state_q != ST_IDLE)
                err_q <= 1'b1;
            else if (stat_wr && wdata_i[1])
                err_q <= 1'b0;
        end
    end

    assign mode_o      = mode_q;
    assign data_o      = shreg_q;
    assign so_o        = so_q;
    assign flag_o      = flag_q;
    assign err_o       = err_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign shifting_o  = (state_q == ST_WAIT_FALL) || (state_q == ST_WAIT_RISE);
    assign want_fall_o = (state_q == ST_WAIT_FALL);

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state_q == ST_WAIT_FALL) |=> (shreg_q == $past(shreg_q))); // R9
    AST_UPPER_NIBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !mode_q.len8) |=> (shreg_q[7:4] == $past(shreg_q[7:4]))); // R5
    AST_FINISH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> flag_q); // R8
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (mode_q == $past(mode_q))); // R10
    AST_SO_HOLDS_TO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RISE) |=> (so_q == $past(so_q))); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (bit_cnt_q <= (mode_q.len8 ? 4'd8 : 4'd4))); // R4
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port
    import sio_pkg::*;
#(
    parameter int HALF_DIV = 4   // block clocks per serial half period, at least 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [3:0] gpio_out,
    input  logic [3:0] gpio_oe,
    input  logic [3:0] pad_in,
    output logic [3:0] pad_out,
    output logic [3:0] pad_oe,
    output logic       irq_req,
    output logic       xfer_flag
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_lvl;
    logic             si_s, sck_s, int_n_s, sck_prev_q;
    logic             s_fall, s_rise, m_fall, m_rise, m_sck;
    logic             fall_ev, rise_ev;
    sio_mode_t        mode;
    logic [7:0]       data;
    logic             so, flag, err, busy, shifting, want_fall;

    sio_sync #(.W(NSYNC), .RST_VAL(3'b111)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({pad_in[3], pad_in[2], pad_in[0]}),
        .sync_o(sync_lvl)
    );
    assign si_s    = sync_lvl[0];
    assign sck_s   = sync_lvl[1];
    assign int_n_s = sync_lvl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b1;
        else        sck_prev_q <= sck_s;
    end
    assign s_fall = sck_prev_q && !sck_s;
    assign s_rise = !sck_prev_q && sck_s;

    sio_master_clk #(.HALF_DIV(HALF_DIV)) i_mclk (
        .clk(clk), .rst_n(rst_n),
        .run_i(shifting && mode.master),
        .want_fall_i(want_fall),
        .fall_o(m_fall), .rise_o(m_rise), .sck_o(m_sck)
    );

    assign fall_ev = mode.master ? m_fall : s_fall;
    assign rise_ev = mode.master ? m_rise : s_rise;

    sio_shift_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .fall_ev_i(fall_ev), .rise_ev_i(rise_ev), .si_i(si_s),
        .mode_o(mode), .data_o(data), .so_o(so), .flag_o(flag),
        .err_o(err), .busy_o(busy), .shifting_o(shifting),
        .want_fall_o(want_fall)
    );

    always_comb begin
        pad_out = gpio_out;
        pad_oe  = gpio_oe;
        if (mode.en) begin
            pad_out[0] = 1'b0;
            pad_oe[0]  = 1'b0;
            pad_out[1] = so;
            pad_oe[1]  = 1'b1;
            pad_out[2] = m_sck;
            pad_oe[2]  = mode.master;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = data;
            ADDR_MODE: bus_rdata = {5'b0, mode.len8, mode.master, mode.en};
            ADDR_STAT: bus_rdata = {5'b0, busy, err, flag};
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign irq_req   = mode.en ? flag : !int_n_s;
    assign xfer_flag = flag;

    AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> m_sck); // R6
endmodule

// File: tb/test_sio_shift_port.sv
module test_sio_shift_port;
    localparam int HALF_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] gpio_out = 4'b1010;
    logic [3:0] gpio_oe  = 4'b0110;
    logic       si_drv = 1'b0, sck_drv = 1'b1, int_n = 1'b1;
    logic [3:0] pad_out, pad_oe;
    logic       irq_req, xfer_flag;

    int total = 0, bad = 0;
    bit finished = 0;
    logic exp_q[$];
    bit bench_master = 0, mon_arm = 0, prev_line = 1;
    string cur_req = "R4";

    always #10 clk = ~clk;

    sio_shift_port #(.HALF_DIV(HALF_DIV)) i_sio_shift_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .pad_in({int_n, sck_drv, 1'b0, si_drv}),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_req(irq_req), .xfer_flag(xfer_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // scoreboard monitor: pops an expected serial bit at every rising clock on the line
    always @(negedge clk) begin
        logic line;
        line = bench_master ? pad_out[2] : sck_drv;
        if (mon_arm && line && !prev_line) begin
            if (exp_q.size() == 0) chk(cur_req, "unexpected serial bit", 1, 0);
            else chk(cur_req, "serial out bit", int'(pad_out[1]), int'(exp_q.pop_front()));
        end
        prev_line = line;
    end

    task automatic xfer(input bit master, input bit len8, input logic [7:0] tx,
                        input logic [7:0] rx, input bit inject);
        int n;
        logic [7:0] rd, want;
        n = len8 ? 8 : 4;
        want = len8 ? rx : {tx[7:4], rx[3:0]};
        cur_req = len8 ? "R4" : "R5";
        for (int i = n - 1; i >= 0; i--) exp_q.push_back(tx[i]);
        bench_master = master;
        bus_write(2'd1, {5'b0, len8, master, 1'b1});
        bus_read(2'd1, rd);
        chk("R10", "mode readback", rd, {5'b0, len8, master, 1'b1});
        prev_line = 1'b1;
        mon_arm = 1;
        bus_write(2'd0, tx);
        bus_read(2'd2, rd);
        chk("R8", "flag cleared by start", rd[0], 0);
        chk("R10", "busy bit", rd[2], 1);
        if (master) begin
            chk("R3", "sck driven in master", pad_oe[2], 1);
            for (int i = 0; i < n; i++) begin
                int lo;
                while (pad_out[2] !== 1'b0) @(negedge clk);
                si_drv = rx[n-1-i];
                lo = 0;
                while (pad_out[2] === 1'b0) begin lo++; @(negedge clk); end
                if (i == 0) chk("R6", "low phase length", lo, HALF_DIV);
            end
        end else begin
            chk("R7", "sck not driven in slave", pad_oe[2], 0);
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                sck_drv = 1'b0; si_drv = rx[n-1-i];
                if (inject && i == 2) begin
                    bus_write(2'd0, 8'h11);
                    bus_write(2'd1, 8'h00);
                    repeat (4) @(negedge clk);
                end else repeat (8) @(negedge clk);
                sck_drv = 1'b1;
                repeat (8) @(negedge clk);
            end
        end
        repeat (10) @(negedge clk);
        mon_arm = 0;
        chk(cur_req, "scoreboard drained", exp_q.size(), 0);
        exp_q.delete();
        bus_read(2'd0, rd);
        chk(cur_req, "received data", rd, want);
        bus_read(2'd2, rd);
        chk("R8", "flag set", rd[0], 1);
        chk("R10", "idle after finish", rd[2], 0);
        chk("R8", "irq from flag", irq_req, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(2'd1, rd); chk("R1", "mode after reset", rd, 0);
        bus_read(2'd2, rd); chk("R1", "status after reset", rd, 0);
        // R2 disabled pass-through and interrupt pin
        chk("R2", "pad_out passthrough", pad_out, gpio_out);
        chk("R2", "pad_oe passthrough", pad_oe, gpio_oe);
        chk("R2", "irq idle", irq_req, 0);
        int_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2", "irq from int pin", irq_req, 1);
        // R3 enabled slave pin mux
        bus_write(2'd1, 8'h01);
        @(negedge clk);
        chk("R3", "si pin input", pad_oe[0], 0);
        chk("R3", "so pin driven", pad_oe[1], 1);
        chk("R3", "sck pin input in slave", pad_oe[2], 0);
        chk("R3", "pin3 stays gpio", {pad_out[3], pad_oe[3]}, {gpio_out[3], gpio_oe[3]});
        chk("R8", "int pin not source when enabled", irq_req, 0);
        // R4 R7 slave 8-bit
        xfer(0, 1, 8'hA5, 8'h3C, 0);
        // R8 sticky flag and clear
        repeat (20) @(negedge clk);
        bus_read(2'd2, rd); chk("R8", "flag sticky", rd[0], 1);
        bus_write(2'd2, 8'h01);
        bus_read(2'd2, rd); chk("R8", "flag cleared", rd[0], 0);
        chk("R8", "irq cleared", irq_req, 0);
        // R5 slave 4-bit
        xfer(0, 0, 8'h9B, 8'h06, 0);
        // R6 master 8-bit and 4-bit
        xfer(1, 1, 8'hC3, 8'h5A, 0);
        xfer(1, 0, 8'h7E, 8'h0D, 0);
        // R9 R10 writes during a transfer
        xfer(0, 1, 8'hF0, 8'h96, 1);
        bus_read(2'd2, rd); chk("R9", "error set", rd[1], 1);
        bus_read(2'd1, rd); chk("R10", "mode write ignored", rd, 8'h05);
        bus_write(2'd2, 8'h02);
        bus_read(2'd2, rd); chk("R9", "error cleared", rd[1], 0);
        // R2 back to gpio
        bus_write(2'd1, 8'h00);
        @(negedge clk);
        chk("R2", "pads back to gpio", {pad_out, pad_oe}, {gpio_out, gpio_oe});
        chk("R2", "irq follows pin again", irq_req, 1);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule